// File: doc/BRIEF.md
# Legacy keyboard port trap controller

This block traps host I/O traffic aimed at the legacy keyboard data port (60h) and command port (64h). Each of the four access kinds (read or write of either port) leaves a sticky flag in one 16-bit control and status register. The register also carries a live copy of the USB controller interrupt and a flag for the end of a gate-A20 pass-through sequence. Per-event enable bits decide which flags reach the system-management interrupt output. A separate enable gates the USB interrupt onto the PCI interrupt output.

Firmware reads and clears the register over a simple read/write bus at byte address C0h. The low and high bytes have separate byte enables. While gate-A20 pass-through is enabled, the SMI output stays low. A small stand-in sequencer provides the pass-through busy state and the end-of-sequence pulse. Firmware can enable an SMI on that end pulse, so that a request held back during the sequence is serviced once it finishes.

Top module: `kbd_trap_ctrl`

## Requirements
- R1: After reset the register at C0h reads 16'h2000, and a read at any other address returns 0.
- R2: One clock after an I/O access is sampled, a flag is set in the register. A read of port 60h sets bit 8, a write of 60h sets bit 9, a read of 64h sets bit 10 and a write of 64h sets bit 11. The full 16-bit address must match, so any other address sets nothing.
- R3: Writing 1 to bit 8, 9, 10, 11 or 15 with the high byte enabled clears that flag. Writing 0 to one of these bits leaves the flag as it is.
- R4: A flag latches even when its enable bit is 0. While every enable is 0, the SMI output stays low.
- R5: With pass-through off, the SMI output is high exactly when an enabled flag is set. Enable bits 0 to 3 pair with flags 8 to 11, and enable bit 4 pairs with bit 12.
- R6: Bit 12 follows the USB interrupt input one clock later. Writing 1 to bit 12 has no effect.
- R7: The PCI interrupt output equals bit 12 AND bit 13. Bit 13 is read/write and resets to 1.
- R8: Bit 14 always reads 0.
- R9: While bit 5 (pass-through enable) is 1, the SMI output is low, whatever the flags and other enables are.
- R10: Bit 6 reads 1 while a pass-through sequence runs. A sequence starts only while bit 5 is 1. Writing 0 to bit 5 clears bit 6 at once and cancels the end pulse.
- R11: When a sequence ends, bit 15 is set. With bit 7 set and bit 5 clear, bit 15 drives the SMI output.
- R12: An event that arrives in the same cycle as a write-1-to-clear of its flag wins, so the flag stays set.
- R13: A write with only the low byte enabled changes bits 0 to 7 only. A write with only the high byte enabled changes bits 8 to 15 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host I/O access in this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O address |
| cfg_en | input | 1 | Register bus access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Register bus byte address |
| cfg_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data (combinational) |
| usb_irq_in | input | 1 | Interrupt from the USB controller |
| a20_start | input | 1 | Starts a stand-in pass-through sequence |
| smi_out | output | 1 | System-management interrupt request |
| pci_irq_out | output | 1 | Gated PCI interrupt |

## Verification
The assertions assume that reset is held for at least one clock before it is released. They also assume that every input changes only between clock edges, so that each I/O access and each register write lasts exactly one sampled cycle. The stimulus drives inputs on the falling edge and holds every strobe for one full period. A sequencer start is issued only after the pass-through enable has been written, except in the one case that checks a start with pass-through off. The bench releases reset only after several clocks.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;

    localparam int REG_W      = 16;
    localparam int N_PORT_EVT = 4;
    localparam int N_SMI_EN   = 5;

    localparam int B_PASS_EN  = 5;
    localparam int B_BUSY     = 6;
    localparam int B_END_EN   = 7;
    localparam int B_PORT_LO  = 8;
    localparam int B_USB      = 12;
    localparam int B_PCI_EN   = 13;
    localparam int B_END      = 15;

    localparam logic [REG_W-1:0] REG_RESET = 16'h2000;

    // Bit order follows the flag order in the register (bits 8..11).
    typedef struct packed {
        logic wr_cmd;
        logic rd_cmd;
        logic wr_data;
        logic rd_data;
    } port_evt_t;

    typedef struct packed {
        logic                pci_en;
        logic                end_en;
        logic                pass_en;
        logic [N_SMI_EN-1:0] smi_en;
    } ctl_t;

    typedef struct packed {
        logic                  end_flag;
        logic                  usb;
        logic [N_PORT_EVT-1:0] port;
    } sts_t;

    function automatic ctl_t ctl_reset();
        ctl_t c;
        c.pci_en  = REG_RESET[B_PCI_EN];
        c.end_en  = REG_RESET[B_END_EN];
        c.pass_en = REG_RESET[B_PASS_EN];
        c.smi_en  = REG_RESET[N_SMI_EN-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(ctl_t c, sts_t s, logic busy);
        logic [REG_W-1:0] r;
        r = '0;
        r[N_SMI_EN-1:0]                    = c.smi_en;
        r[B_PASS_EN]                       = c.pass_en;
        r[B_BUSY]                          = busy & c.pass_en;
        r[B_END_EN]                        = c.end_en;
        r[B_PORT_LO+N_PORT_EVT-1:B_PORT_LO] = s.port;
        r[B_USB]                           = s.usb;
        r[B_PCI_EN]                        = c.pci_en;
        r[B_END]                           = s.end_flag;
        return r;
    endfunction

endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode
    import kbd_trap_pkg::*;
#(
    parameter int                IO_AW     = 16,
    parameter logic [IO_AW-1:0]  DATA_PORT = 'h60,
    parameter logic [IO_AW-1:0]  CMD_PORT  = 'h64
) (
    input  logic             io_valid,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    output port_evt_t        evt
);
    logic hit_data, hit_cmd;

    assign hit_data = io_valid && (io_addr == DATA_PORT);
    assign hit_cmd  = io_valid && (io_addr == CMD_PORT);

    always_comb begin
        evt         = '0;
        evt.rd_data = hit_data && !io_write;
        evt.wr_data = hit_data &&  io_write;
        evt.rd_cmd  = hit_cmd  && !io_write;
        evt.wr_cmd  = hit_cmd  &&  io_write;
    end
endmodule

// File: rtl/a20_stub_seq.sv
module a20_stub_seq #(
    parameter int SEQ_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pass_en,
    input  logic start,
    output logic busy,
    output logic end_pulse
);
    localparam int CW = (SEQ_LEN < 2) ? 1 : $clog2(SEQ_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pass_en) begin
            busy      <= 1'b0;
            cnt       <= '0;
            end_pulse <= 1'b0;
        end else begin
            end_pulse <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy      <= 1'b0;
                    end_pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= CW'(SEQ_LEN - 1);
            end
        end
    end

    AST_BUSY_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst)
        !$past(pass_en) |-> !busy && !end_pulse);                // R10
    AST_END_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        end_pulse |-> $past(busy));                              // R11
endmodule

// File: rtl/kbd_trap_regs.sv
module kbd_trap_regs
    import kbd_trap_pkg::*;
#(
    parameter int                 CFG_AW   = 8,
    parameter logic [CFG_AW-1:0]  REG_ADDR = 'hC0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [1:0]         cfg_be,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  port_evt_t          evt,
    input  logic               usb_irq_in,
    input  logic               seq_busy,
    input  logic               seq_end,
    output ctl_t               ctl,
    output sts_t               sts
);
    logic                  sel, wr_lo, wr_hi;
    logic [N_PORT_EVT-1:0] evt_vec, clr_port;
    logic                  clr_end;
    logic                  unused_wbits;

    assign sel      = cfg_en && (cfg_addr == REG_ADDR);
    assign wr_lo    = sel && cfg_we && cfg_be[0];
    assign wr_hi    = sel && cfg_we && cfg_be[1];
    assign evt_vec  = evt;
    assign clr_port = wr_hi ? cfg_wdata[B_PORT_LO+N_PORT_EVT-1:B_PORT_LO] : '0;
    assign clr_end  = wr_hi && cfg_wdata[B_END];
    assign unused_wbits = ^{cfg_wdata[14], cfg_wdata[B_USB], cfg_wdata[B_BUSY]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= ctl_reset();
            sts <= '0;
        end else begin
            if (wr_lo) begin
                ctl.smi_en  <= cfg_wdata[N_SMI_EN-1:0];
                ctl.pass_en <= cfg_wdata[B_PASS_EN];
                ctl.end_en  <= cfg_wdata[B_END_EN];
            end
            if (wr_hi) begin
                ctl.pci_en <= cfg_wdata[B_PCI_EN];
            end
            // set beats clear when both land in one cycle
            sts.port     <= (sts.port & ~clr_port) | evt_vec;
            sts.end_flag <= (sts.end_flag & ~clr_end) | seq_end;
            sts.usb      <= usb_irq_in;
        end
    end

    assign cfg_rdata = (sel && !cfg_we) ? pack_reg(ctl, sts, seq_busy) : '0;

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_vec) & ~sts.port) == '0);                     // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(sts.port) & ~$past(clr_port) & ~sts.port) == '0); // R3
    AST_END_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(sts.end_flag) && !$past(clr_end) |-> sts.end_flag); // R11
endmodule

// File: rtl/kbd_irq_combine.sv
module kbd_irq_combine
    import kbd_trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  sts_t sts,
    output logic smi_out,
    output logic pci_irq_out
);
    logic [N_SMI_EN-1:0] src;
    logic                any_src;

    assign src         = {sts.usb, sts.port};
    assign any_src     = |(src & ctl.smi_en) || (sts.end_flag && ctl.end_en);
    assign smi_out     = any_src && !ctl.pass_en;
    assign pci_irq_out = sts.usb && ctl.pci_en;

    AST_PASS_MUTES_SMI: assert property (@(posedge clk) disable iff (rst)
        ctl.pass_en |-> !smi_out);                               // R9
    AST_PCI_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctl.pci_en |-> !pci_irq_out);                           // R7
    AST_NO_EN_NO_SMI: assert property (@(posedge clk) disable iff (rst)
        (ctl.smi_en == '0) && !ctl.end_en |-> !smi_out);         // R4
endmodule

// File: rtl/kbd_trap_ctrl.sv
module kbd_trap_ctrl
    import kbd_trap_pkg::*;
#(
    parameter int                 CFG_AW    = 8,
    parameter logic [CFG_AW-1:0]  REG_ADDR  = 'hC0,
    parameter int                 IO_AW     = 16,
    parameter logic [IO_AW-1:0]   DATA_PORT = 'h60,
    parameter logic [IO_AW-1:0]   CMD_PORT  = 'h64,
    parameter int                 SEQ_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [1:0]        cfg_be,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              usb_irq_in,
    input  logic              a20_start,
    output logic              smi_out,
    output logic              pci_irq_out
);
    port_evt_t evt;
    ctl_t      ctl;
    sts_t      sts;
    logic      seq_busy, seq_end;

    kbd_port_decode #(
        .IO_AW(IO_AW), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
    ) u_dec (
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr), .evt(evt)
    );

    a20_stub_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
        .clk(clk), .rst(rst), .pass_en(ctl.pass_en), .start(a20_start),
        .busy(seq_busy), .end_pulse(seq_end)
    );

    kbd_trap_regs #(.CFG_AW(CFG_AW), .REG_ADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .evt(evt), .usb_irq_in(usb_irq_in),
        .seq_busy(seq_busy), .seq_end(seq_end), .ctl(ctl), .sts(sts)
    );

    kbd_irq_combine u_irq (
        .clk(clk), .rst(rst), .ctl(ctl), .sts(sts),
        .smi_out(smi_out), .pci_irq_out(pci_irq_out)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[14]);                                         // R8
endmodule

// File: tb/kbd_trap_ctrl_test.sv
`timescale 1ns/1ps
module kbd_trap_ctrl_test;
    localparam int SEQ_LEN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'hC0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        usb_irq_in = 1'b0, a20_start = 1'b0;
    logic        smi_out, pci_irq_out;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kbd_trap_ctrl #(.SEQ_LEN(SEQ_LEN)) uut (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .usb_irq_in(usb_irq_in), .a20_start(a20_start),
        .smi_out(smi_out), .pci_irq_out(pci_irq_out)
    );

    // {write, address} and the expected value of bits 11..8
    localparam logic [16:0] VEC_IN [0:5] = '{
        {1'b0, 16'h0060}, {1'b1, 16'h0060}, {1'b0, 16'h0064},
        {1'b1, 16'h0064}, {1'b0, 16'h0061}, {1'b1, 16'h0160}};
    localparam logic [3:0] VEC_EXP [0:5] = '{
        4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000, 4'b0000};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_at(input logic [7:0] a, output logic [15:0] v);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        #1 v = cfg_rdata;
        cfg_en = 1'b0; cfg_addr = 8'hC0;
    endtask

    task automatic rd(output logic [15:0] v);
        rd_at(8'hC0, v);
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        tick(1);
        cfg_en = 1'b0; cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic io(input logic w, input logic [15:0] a);
        io_valid = 1'b1; io_write = w; io_addr = a;
        tick(1);
        io_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd(v);              chk("R1 reset value", v, 16'h2000);
        rd_at(8'hC2, v);    chk("R1 other address", v, 16'h0000);
        chk("R1 smi idle", {15'd0, smi_out}, 16'd0);
        chk("R7 pci idle", {15'd0, pci_irq_out}, 16'd0);

        // R2 / R4 vector table, all enables off
        for (int i = 0; i < 6; i++) begin
            wr(2'b10, 16'h2F00);
            io(VEC_IN[i][16], VEC_IN[i][15:0]);
            rd(v);
            chk("R2 port flag", {12'd0, v[11:8]}, {12'd0, VEC_EXP[i]});
            chk("R4 no smi without enable", {15'd0, smi_out}, 16'd0);
        end

        // R3 write-1-to-clear
        wr(2'b10, 16'h2F00);
        io(1'b0, 16'h0060);
        io(1'b1, 16'h0064);
        rd(v);  chk("R2 two flags", v, 16'h2900);
        wr(2'b10, 16'h2100);
        rd(v);  chk("R3 clear bit8", v, 16'h2800);
        wr(2'b10, 16'h2000);
        rd(v);  chk("R3 zero leaves flag", v, 16'h2800);
        wr(2'b10, 16'h2F00);

        // R5 enable pairing
        wr(2'b01, 16'h0001);
        chk("R5 enable no flag", {15'd0, smi_out}, 16'd0);
        io(1'b0, 16'h0060);
        chk("R5 enabled flag", {15'd0, smi_out}, 16'd1);
        wr(2'b01, 16'h0002);
        chk("R5 mismatched enable", {15'd0, smi_out}, 16'd0);
        wr(2'b10, 16'h2F00);

        // R6 / R7 USB mirror and PCI gating
        usb_irq_in = 1'b1;
        tick(1);
        rd(v);  chk("R6 usb mirror", v & 16'h1000, 16'h1000);
        chk("R7 pci follows", {15'd0, pci_irq_out}, 16'd1);
        wr(2'b10, 16'h1000);
        rd(v);  chk("R6 write one ignored", v, 16'h1002);
        chk("R7 pci gated", {15'd0, pci_irq_out}, 16'd0);
        wr(2'b01, 16'h0010);
        chk("R5 usb enable", {15'd0, smi_out}, 16'd1);
        usb_irq_in = 1'b0;
        tick(1);
        rd(v);  chk("R6 usb cleared", v, 16'h0010);
        chk("R6 smi drops", {15'd0, smi_out}, 16'd0);
        wr(2'b11, 16'h2000);

        // R8 / R9 reserved bit, pass-through mutes SMI
        wr(2'b11, 16'hFFFF);
        rd(v);  chk("R8 reserved zero", v, 16'h20BF);
        io(1'b0, 16'h0060);
        chk("R9 smi muted", {15'd0, smi_out}, 16'd0);
        wr(2'b01, 16'h009F);
        chk("R9 smi after pass off", {15'd0, smi_out}, 16'd1);
        wr(2'b11, 16'h2F00);

        // R13 byte enables
        wr(2'b01, 16'h5F1F);
        rd(v);  chk("R13 low byte only", v, 16'h201F);
        wr(2'b10, 16'h0000);
        rd(v);  chk("R13 high byte only", v, 16'h001F);
        wr(2'b11, 16'h2000);

        // R12 set beats clear
        io_valid = 1'b1; io_write = 1'b0; io_addr = 16'h0060;
        wr(2'b10, 16'h2100);
        io_valid = 1'b0;
        rd(v);  chk("R12 event wins", v, 16'h2100);
        wr(2'b10, 16'h2100);
        rd(v);  chk("R3 clear after race", v, 16'h2000);

        // R10 / R11 pass-through sequence
        wr(2'b01, 16'h0020);
        a20_start = 1'b1; tick(1); a20_start = 1'b0;
        rd(v);  chk("R10 busy shown", v, 16'h2060);
        tick(SEQ_LEN + 3);
        rd(v);  chk("R11 end flag", v, 16'hA020);
        chk("R9 end muted", {15'd0, smi_out}, 16'd0);
        wr(2'b01, 16'h0080);
        chk("R11 end smi", {15'd0, smi_out}, 16'd1);
        wr(2'b10, 16'hA000);
        rd(v);  chk("R3 end cleared", v, 16'h2080);
        chk("R11 smi drops", {15'd0, smi_out}, 16'd0);

        // R10 abort and start while disabled
        wr(2'b01, 16'h0020);
        a20_start = 1'b1; tick(1); a20_start = 1'b0;
        rd(v);  chk("R10 busy again", v, 16'h2060);
        wr(2'b01, 16'h0000);
        rd(v);  chk("R10 abort clears busy", v, 16'h2000);
        tick(SEQ_LEN + 3);
        rd(v);  chk("R10 abort no end flag", v, 16'h2000);
        a20_start = 1'b1; tick(1); a20_start = 1'b0;
        rd(v);  chk("R10 start ignored", v, 16'h2000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule